// File: doc/BRIEF.md
# Embedded Core Control Register Block

This block gives a host processor control over a small embedded core through three registers on a simple single-cycle read/write bus. The host can hold the core in a stopped state and start it again. It can run a timed reset of the core and load a new start address into the core's program counter. It can also collect error and status events that the core raises. Reads are combinational from the address. Writes take effect on the clock edge on which `bus_wr` is high.

A control sequencer made of an enumerated state machine decides whether the core runs, is stopped or is being reset. It has three states:

- `CS_RUN`: the core runs.
- `CS_HALT`: the core is stopped.
- `CS_RESET`: the timed internal reset is in progress.

The transitions are:

- `RUN->HALT` on a control write with the stop bit set.
- `HALT->RUN` on a control write with the stop bit clear.
- `RUN->RESET` and `HALT->RESET` on a control write with the reset bit set.
- `RESET->RUN` or `RESET->HALT` when the countdown reaches zero. The choice depends on the last stop bit written.

Each status bit is a sticky flag with write-one-to-clear. The program counter register is shared between the host and the core. An update from the core takes priority over a host write in the same cycle, so the host should stop the core first and then read the value back to verify it.

Top module: `corectl_top`

## Requirements
- R1: After `rst_n` is released, every register reads zero, `core_rst` and `core_halt` are low, and `core_pc` is zero.
- R2: A write to the control register (offset 0x00) with bit 0 set, made while no reset is running, raises `core_rst` for exactly RST_CYC cycles. Bit 0 of the control register reads back 1 during that window and 0 afterwards.
- R3: From the edge that starts the reset until the countdown ends, `core_pc` is held at 0, the status register stays at 0, and core events and core PC updates have no effect.
- R4: Bit 10 of the control register is the stop bit. A control write copies `bus_wdata[10]` into it, and it appears on `core_halt` and in read-back bit 10 from the next cycle on. Writing 0x00 lets the core run. All other control bits read 0.
- R5: When the stop bit is written during or together with a reset, it takes effect at the end of the reset, and `core_halt` stays at that value.
- R6: A high level on bit k of `core_evt` (bit 0 illegal instruction, bit 1 bus error, bit 2 core halted) sets status bit k of the register at offset 0x04. The bit stays set until it is cleared.
- R7: Writing to offset 0x04 clears every status bit whose data bit is 1. An event on the same edge wins over the clear. Bits 31:3 of the status register read 0.
- R8: A host write to offset 0x1C loads `bus_wdata[PC_W-1:0]` into the program counter. The register reads back zero-extended.
- R9: While the core is running and not in reset, `core_pc_upd` loads `core_pc_nxt` into the program counter. This load overrides a host write on the same edge.
- R10: While the core is stopped, `core_pc_upd` is ignored, so a host-loaded value is kept.
- R11: Reads of any other offset return 0. Writes to other offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| core_rst | output | 1 | Core reset, high during the countdown |
| core_halt | output | 1 | Stop level toward the core |
| core_pc | output | PC_W | Current program counter |
| core_pc_upd | input | 1 | Core requests a program counter advance |
| core_pc_nxt | input | PC_W | Next program counter from the core |
| core_evt | input | EVT_W | Event pulses from the core |

## Verification
The bench builds the block with RST_CYC = 5 and PC_W = 12. The short countdown makes many complete reset windows fit in the run, including control writes that land on the last reset cycle. The narrow counter makes the truncation of wide host data and of the core's next address visible at every program counter write. A random phase mixes host writes and core advances on the same edge, events against clears, and resets started while stopped. It compares the block against a behavioural model on every cycle.

// File: rtl/corectl_pkg.sv
package corectl_pkg;

    typedef enum logic [1:0] {
        CS_RUN   = 2'd0,
        CS_HALT  = 2'd1,
        CS_RESET = 2'd2
    } ctl_state_e;

    localparam int CTL_RST_BIT  = 0;
    localparam int CTL_STOP_BIT = 10;

    localparam int OFS_CTL = 'h00;
    localparam int OFS_STS = 'h04;
    localparam int OFS_PC  = 'h1C;

endpackage

// File: rtl/corectl_seq.sv
module corectl_seq
    import corectl_pkg::*;
#(
    parameter int RST_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_rst_req,
    input  logic ctl_stop_req,
    output logic rst_go,
    output logic in_reset,
    output logic halt_lvl
);

    localparam int CNT_W = $clog2(RST_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYC - 1);

    ctl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             stop_q;
    logic             stop_next;

    assign rst_go    = ctl_wr && ctl_rst_req && (state_q != CS_RESET);
    assign stop_next = ctl_wr ? ctl_stop_req : stop_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CS_RUN: begin
                if (rst_go) begin
                    state_d = CS_RESET;
                    cnt_d   = CNT_LOAD;
                end else if (ctl_wr && ctl_stop_req) begin
                    state_d = CS_HALT;
                end
            end
            CS_HALT: begin
                if (rst_go) begin
                    state_d = CS_RESET;
                    cnt_d   = CNT_LOAD;
                end else if (ctl_wr && !ctl_stop_req) begin
                    state_d = CS_RUN;
                end
            end
            CS_RESET: begin
                if (cnt_q == '0) begin
                    state_d = stop_next ? CS_HALT : CS_RUN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = CS_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_RUN;
            cnt_q   <= '0;
            stop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            stop_q  <= stop_next;
        end
    end

    always_comb begin
        in_reset = (state_q == CS_RESET);
        halt_lvl = (state_q == CS_HALT) || ((state_q == CS_RESET) && stop_q);
    end

endmodule

// File: rtl/corectl_sticky.sv
module corectl_sticky #(
    parameter int EVT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic [EVT_W-1:0] evt,
    input  logic             w1c_en,
    input  logic [EVT_W-1:0] w1c_mask,
    output logic [EVT_W-1:0] flags
);

    for (genvar g = 0; g < EVT_W; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (clr_all) begin
                flags[g] <= 1'b0;
            end else if (evt[g]) begin
                flags[g] <= 1'b1;
            end else if (w1c_en && w1c_mask[g]) begin
                flags[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/corectl_pcreg.sv
module corectl_pcreg #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            hold,
    input  logic            core_upd,
    input  logic [PC_W-1:0] core_nxt,
    input  logic            host_wr,
    input  logic [PC_W-1:0] host_val,
    output logic [PC_W-1:0] pc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (clr) begin
            pc <= '0;
        end else if (core_upd && !hold) begin
            pc <= core_nxt;
        end else if (host_wr) begin
            pc <= host_val;
        end
    end

endmodule

// File: rtl/corectl_top.sv
module corectl_top
    import corectl_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int PC_W    = 16,
    parameter int RST_CYC = 8,
    parameter int EVT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              core_rst,
    output logic              core_halt,
    output logic [PC_W-1:0]   core_pc,
    input  logic              core_pc_upd,
    input  logic [PC_W-1:0]   core_pc_nxt,
    input  logic [EVT_W-1:0]  core_evt
);

    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_PC  = ADDR_W'(OFS_PC);

    logic             sel_ctl, sel_sts, sel_pc;
    logic             rst_go, in_reset, halt_lvl, clr_now;
    logic [EVT_W-1:0] sts_q;
    logic [PC_W-1:0]  pc_q;

    assign sel_ctl = bus_wr && (bus_addr == A_CTL);
    assign sel_sts = bus_wr && (bus_addr == A_STS);
    assign sel_pc  = bus_wr && (bus_addr == A_PC);
    assign clr_now = rst_go || in_reset;

    corectl_seq #(.RST_CYC(RST_CYC)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (sel_ctl),
        .ctl_rst_req  (bus_wdata[CTL_RST_BIT]),
        .ctl_stop_req (bus_wdata[CTL_STOP_BIT]),
        .rst_go       (rst_go),
        .in_reset     (in_reset),
        .halt_lvl     (halt_lvl)
    );

    corectl_sticky #(.EVT_W(EVT_W)) sts_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (clr_now),
        .evt      (core_evt),
        .w1c_en   (sel_sts),
        .w1c_mask (bus_wdata[EVT_W-1:0]),
        .flags    (sts_q)
    );

    corectl_pcreg #(.PC_W(PC_W)) pc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_now),
        .hold     (halt_lvl),
        .core_upd (core_pc_upd),
        .core_nxt (core_pc_nxt),
        .host_wr  (sel_pc),
        .host_val (bus_wdata[PC_W-1:0]),
        .pc       (pc_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTL) begin
            bus_rdata[CTL_RST_BIT]  = in_reset;
            bus_rdata[CTL_STOP_BIT] = halt_lvl;
        end else if (bus_addr == A_STS) begin
            bus_rdata[EVT_W-1:0] = sts_q;
        end else if (bus_addr == A_PC) begin
            bus_rdata[PC_W-1:0] = pc_q;
        end
    end

    assign core_rst  = in_reset;
    assign core_halt = halt_lvl;
    assign core_pc   = pc_q;

endmodule

// File: rtl/corectl_chk.sv
module corectl_chk
    import corectl_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int PC_W    = 16,
    parameter int RST_CYC = 8,
    parameter int EVT_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              core_rst,
    input logic              core_halt,
    input logic [PC_W-1:0]   core_pc,
    input logic              core_pc_upd,
    input logic [PC_W-1:0]   core_pc_nxt,
    input logic [EVT_W-1:0]  core_evt,
    input logic              rst_go,
    input logic [EVT_W-1:0]  sts_q
);

    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_PC  = ADDR_W'(OFS_PC);

    logic [31:0] rst_run;
    logic [DATA_W-1:0] ctl_ok_mask;

    always_comb begin
        ctl_ok_mask = '0;
        ctl_ok_mask[CTL_RST_BIT]  = 1'b1;
        ctl_ok_mask[CTL_STOP_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rst_run <= '0;
        else if (core_rst) rst_run <= rst_run + 1;
        else               rst_run <= '0;
    end

    AST_RST_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (rst_run < 32'(RST_CYC))); // R2
    AST_RST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> (rst_run == 32'(RST_CYC))); // R2
    AST_RST_BIT_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTL) |-> (bus_rdata[CTL_RST_BIT] == core_rst)); // R2
    AST_PC_ZERO_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (core_pc == '0)); // R3
    AST_STS_ZERO_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && bus_addr == A_STS) |-> (bus_rdata == '0)); // R3
    AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTL) |-> ((bus_rdata & ~ctl_ok_mask) == '0)); // R4
    AST_STOP_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTL) |-> (bus_rdata[CTL_STOP_BIT] == core_halt)); // R4
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_evt != '0) && !core_rst && !rst_go) |=> ((sts_q & $past(core_evt)) == $past(core_evt))); // R6
    AST_CORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_halt && !core_rst && !rst_go && core_pc_upd) |=> (core_pc == $past(core_pc_nxt))); // R9
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halt && !core_rst && !rst_go && !(bus_wr && bus_addr == A_PC)) |=> $stable(core_pc)); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != A_CTL && bus_addr != A_STS && bus_addr != A_PC) |-> (bus_rdata == '0)); // R11

endmodule

bind corectl_top corectl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PC_W    (PC_W),
    .RST_CYC (RST_CYC),
    .EVT_W   (EVT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .core_rst    (core_rst),
    .core_halt   (core_halt),
    .core_pc     (core_pc),
    .core_pc_upd (core_pc_upd),
    .core_pc_nxt (core_pc_nxt),
    .core_evt    (core_evt),
    .rst_go      (rst_go),
    .sts_q       (sts_q)
);

// File: tb/corectl_top_tb_top.sv
`timescale 1ns/1ps
module corectl_top_tb_top;

    localparam int AW   = 8;
    localparam int DW   = 32;
    localparam int PW   = 12;
    localparam int RC   = 5;
    localparam int EW   = 3;
    localparam int MASK = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          core_rst, core_halt;
    logic [PW-1:0] core_pc;
    logic          core_pc_upd = 1'b0;
    logic [PW-1:0] core_pc_nxt = '0;
    logic [EW-1:0] core_evt = '0;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    int m_cnt = 0;
    int m_halt = 0;
    int m_sts = 0;
    int m_pc = 0;

    always #4 clk = ~clk;

    corectl_top #(.ADDR_W(AW), .DATA_W(DW), .PC_W(PW), .RST_CYC(RC), .EVT_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_rst(core_rst),
        .core_halt(core_halt), .core_pc(core_pc), .core_pc_upd(core_pc_upd),
        .core_pc_nxt(core_pc_nxt), .core_evt(core_evt)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mread(logic [AW-1:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00) begin
            r[0]  = (m_cnt > 0);
            r[10] = (m_halt != 0);
        end else if (a == 8'h04) r = 32'(m_sts);
        else if (a == 8'h1C) r = 32'(m_pc);
        return r;
    endfunction

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_halt = 0; m_sts = 0; m_pc = 0;
        end else begin
            bit in_r, start, clr;
            int npc, nsts;
            in_r  = (m_cnt > 0);
            start = bus_wr && bus_addr == 8'h00 && bus_wdata[0] && !in_r;
            clr   = start || in_r;
            npc  = m_pc;
            nsts = m_sts;
            if (clr) begin
                npc = 0; nsts = 0;
            end else begin
                if (core_pc_upd && m_halt == 0) npc = int'(core_pc_nxt) & MASK;
                else if (bus_wr && bus_addr == 8'h1C) npc = int'(bus_wdata) & MASK;
                if (bus_wr && bus_addr == 8'h04) nsts = nsts & ~(int'(bus_wdata) & 7);
                nsts = nsts | int'(core_evt);
            end
            m_pc = npc; m_sts = nsts;
            if (start) m_cnt = RC;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (bus_wr && bus_addr == 8'h00) m_halt = int'(bus_wdata[10]);
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tg;
            chk("R2 core_rst", 32'(core_rst), 32'(m_cnt > 0));
            chk("R4 core_halt", 32'(core_halt), 32'(m_halt != 0));
            chk("R9 core_pc", 32'(core_pc), 32'(m_pc));
            case (bus_addr)
                8'h00:   tg = "R4 ctl read";
                8'h04:   tg = "R6 status read";
                8'h1C:   tg = "R8 pc read";
                default: tg = "R11 unmapped read";
            endcase
            chk(tg, bus_rdata, mread(bus_addr));
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [AW-1:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 ctl", 8'h00, 0);
        rd_chk("R1 sts", 8'h04, 0);
        rd_chk("R1 pc", 8'h1C, 0);
        chk("R1 core_rst", 32'(core_rst), 0);
        chk("R1 core_halt", 32'(core_halt), 0);
        step();

        // R4 stop, R8/R10 host load while stopped with core advancing
        wr(8'h00, 32'h400);
        chk("R4 halt level", 32'(core_halt), 1);
        rd_chk("R4 ctl readback", 8'h00, 32'h400);
        core_pc_upd = 1'b1; core_pc_nxt = 12'h123;
        wr(8'h1C, 32'hFFFF_FABC);
        rd_chk("R8 pc readback truncated", 8'h1C, 32'hABC);
        repeat (3) step();
        chk("R10 pc held while stopped", 32'(core_pc), 32'hABC);

        // R9 run: core advance wins over host write
        wr(8'h00, 32'h0);
        chk("R4 run after 0x00", 32'(core_halt), 0);
        core_pc_nxt = 12'h456;
        wr(8'h1C, 32'h777);
        chk("R9 core wins same edge", 32'(core_pc), 32'h456);
        core_pc_upd = 1'b0;
        wr(8'h1C, 32'h777);
        chk("R8 host load idle core", 32'(core_pc), 32'h777);

        // R6 sticky, R7 write-one-to-clear
        core_evt = 3'b101; step(); core_evt = 3'b000;
        repeat (2) step();
        rd_chk("R6 sticky events", 8'h04, 32'h5);
        core_evt = 3'b010;
        wr(8'h04, 32'h1);
        core_evt = 3'b000;
        rd_chk("R7 clear one, event kept", 8'h04, 32'h6);
        core_evt = 3'b100;
        wr(8'h04, 32'hFFFF_FFFF);
        core_evt = 3'b000;
        rd_chk("R7 event beats clear", 8'h04, 32'h4);
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R7 all cleared", 8'h04, 32'h0);

        // R2/R3/R5 reset combined with stop
        wr(8'h1C, 32'h3AA);
        core_evt = 3'b111; core_pc_upd = 1'b1;
        wr(8'h00, 32'h401);
        n = 0;
        while (core_rst && n < 100) begin
            n++;
            chk("R3 pc zero in reset", 32'(core_pc), 0);
            rd_chk("R3 status zero in reset", 8'h04, 0);
            rd_chk("R2 reset bit reads 1", 8'h00, 32'h401);
            step();
        end
        core_evt = 3'b000; core_pc_upd = 1'b0;
        chk("R2 reset length", 32'(n), 32'(RC));
        rd_chk("R2 reset bit cleared", 8'h00, 32'h400);
        chk("R5 stop kept after reset", 32'(core_halt), 1);
        chk("R3 pc zero after reset", 32'(core_pc), 0);

        // R5 stop cleared during reset
        wr(8'h00, 32'h401);
        step();
        wr(8'h00, 32'h0);
        repeat (RC) step();
        chk("R5 run after reset", 32'(core_halt), 0);

        // R11 unmapped
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk("R11 unmapped read", 8'h08, 0);
        rd_chk("R11 ctl untouched", 8'h00, 0);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = int'($urandom % 8);
            bus_wr = 1'b0;
            bus_wdata = $urandom;
            case (op)
                0: begin
                    bus_wr = 1'b1; bus_addr = 8'h00;
                    bus_wdata = (($urandom % 5) == 0 ? 32'h1 : 32'h0) | (32'($urandom % 2) << 10);
                end
                1: begin bus_wr = 1'b1; bus_addr = 8'h04; end
                2, 3: begin bus_wr = 1'b1; bus_addr = 8'h1C; end
                4: begin bus_wr = 1'b1; bus_addr = (($urandom % 2) == 0) ? 8'h08 : 8'h10; end
                default: begin
                    case ($urandom % 4)
                        0: bus_addr = 8'h00;
                        1: bus_addr = 8'h04;
                        2: bus_addr = 8'h1C;
                        default: bus_addr = 8'h0C;
                    endcase
                end
            endcase
            core_evt    = (($urandom % 6) == 0) ? EW'($urandom) : '0;
            core_pc_upd = $urandom % 2;
            core_pc_nxt = PW'($urandom);
            step();
        end
        bus_wr = 1'b0;
        step();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule